// File: doc/BRIEF.md
# Stochastic Length-4 Polar Successive-Cancellation Decoder

This block recovers the four message bits of a length-4 polar codeword. Every soft value inside it is a stochastic bit-stream: one bit per clock, and the fraction of ones in the stream equals the probability that the underlying bit is 1. An external source supplies four channel streams on `ch_bits`, one lane per codeword position (lane 0 is y1 through lane 3 is y4). A mask marks the frozen message positions. A start pulse launches a decode, and a length select sets the stream period to a power of two.

The decoder takes six steps, and each step lasts exactly one stream period:

- **Step 1:** the two first-stage f nodes (XOR) run on the channel streams. Their outputs go into a two-lane stream buffer.
- **Steps 2 and 3:** the last-stage f node and then the last-stage g node read the buffer back. They feed a ones-counter that decides u1 and then u2.
- **Step 4:** the two first-stage g nodes run on fresh channel streams, steered by the partial sums u1^u2 and u2, and refill the buffer.
- **Steps 5 and 6:** these steps decide u3 and u4 in the same way as steps 2 and 3.

A one-cycle done pulse follows the last decision. The bits stay on `u_bits` until the next decode starts.

Top module: `sc4_polar_decoder`

## Requirements
- R1: While reset is asserted and after reset is released, `done` is 0 and `u_bits` is 0 until a decode completes.
- R2: `len_sel` is sampled with an accepted start. The stream length is L = 2^len_sel, and any value above 10 is treated as 10. `done` rises in the cycle that follows the 6·L-th clock edge after the edge that accepted start.
- R3: The f node output is the XOR of its two input streams. u1 is the hard decision of the stream (y1^y3)^(y2^y4), taken over the step-1 samples held in the buffer.
- R4: A hard decision is 1 only when the count of ones over the L bits of a step is strictly greater than L/2. A tie gives 0.
- R5: The g node inverts its first input when its partial sum is 1. When the two inputs then agree, it outputs that value. Otherwise it repeats its previous output bit, and that previous bit is taken as 0 in the first cycle of every step.
- R6: u2 is the hard decision of the g node fed by the two buffered step-1 streams (y1^y3 first, y2^y4 second), with partial sum u1.
- R7: In step 4, one g node takes (y1, y3) with partial sum u1^u2 and the other takes (y2, y4) with partial sum u2. u3 is the decision of the XOR of their outputs, and u4 is the decision of a g node on them with partial sum u3.
- R8: `ch_bits` is sampled only during steps 1 and 4. Its value in steps 2, 3, 5 and 6 has no effect on the result.
- R9: `frozen_mask` is sampled with an accepted start. When bit k of the mask is 1, message bit k (bit 0 = u1) is 0, and that 0 also serves as the partial sum for later steps.
- R10: `done` is high for exactly one cycle. `u_bits` (bit 0 = u1 through bit 3 = u4) keeps its value until the next accepted start, which clears it to 0.
- R11: A start pulse that arrives while a decode is running is ignored. The latched length and mask are unchanged, and so are the timing of done and the decoded bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a decode when the block is idle |
| len_sel | input | 4 | Log2 of the stream length, sampled at start |
| frozen_mask | input | 4 | Frozen message positions, bit 0 = u1 |
| ch_bits | input | 4 | One bit of each channel stream, lane 0 = y1 |
| u_bits | output | 4 | Decided message bits, bit 0 = u1 |
| done | output | 1 | One-cycle pulse when all four bits are decided |

## Verification
The bench drives a single-bit period, the shortest case. If the design mishandles it, the end-of-step detection slips and done lands in the wrong cycle. A two-bit period with exactly one 1 in the first-stage stream checks the tie rule; a design that rounds ties upward decodes u1 as 1. A clamped length select, start pulses during a running decode, and random channel bits during the buffered steps each expose a design that re-latches the length, restarts, or reads the channel when it should replay the buffer. All-frozen masks, and masks that freeze some positions, catch a design that feeds the computed decision rather than the forced 0 into the later partial sums.

// File: rtl/sc4_pkg.sv
package sc4_pkg;

  localparam int CW_BITS = 4;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_STAGE1_F = 3'd1,
    PH_DEC_U1   = 3'd2,
    PH_DEC_U2   = 3'd3,
    PH_STAGE1_G = 3'd4,
    PH_DEC_U3   = 3'd5,
    PH_DEC_U4   = 3'd6
  } phase_e;

endpackage

// File: rtl/sc4_sequencer.sv
module sc4_sequencer
  import sc4_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  parameter int LSEL_W   = $clog2(MAX_LOG2 + 1),
  localparam int LW      = MAX_LOG2 + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LSEL_W-1:0]   len_sel,
  output phase_e              phase,
  output logic [MAX_LOG2-1:0] idx,
  output logic [LW-1:0]       len_cur,
  output logic                first,
  output logic                last,
  output logic                accept,
  output logic                done
);

  phase_e              phase_q, phase_d;
  logic [MAX_LOG2-1:0] idx_q, idx_d;
  logic [LW-1:0]       len_q, len_d;
  logic                done_q, done_d;
  logic [LSEL_W-1:0]   sel_c;
  logic [LW-1:0]       len_new;
  phase_e              phase_nx;

  // length select, clamped to the largest supported period
  always_comb begin
    sel_c   = (len_sel > LSEL_W'(MAX_LOG2)) ? LSEL_W'(MAX_LOG2) : len_sel;
    len_new = LW'(1) << sel_c;
  end

  assign accept = start && (phase_q == PH_IDLE);
  assign first  = (phase_q != PH_IDLE) && (idx_q == '0);
  assign last   = (phase_q != PH_IDLE) && ({1'b0, idx_q} == (len_q - LW'(1)));

  always_comb begin
    case (phase_q)
      PH_STAGE1_F: phase_nx = PH_DEC_U1;
      PH_DEC_U1:   phase_nx = PH_DEC_U2;
      PH_DEC_U2:   phase_nx = PH_STAGE1_G;
      PH_STAGE1_G: phase_nx = PH_DEC_U3;
      PH_DEC_U3:   phase_nx = PH_DEC_U4;
      default:     phase_nx = PH_IDLE;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    len_d   = len_q;
    done_d  = 1'b0;
    if (accept) begin
      phase_d = PH_STAGE1_F;
      idx_d   = '0;
      len_d   = len_new;
    end else if (phase_q != PH_IDLE) begin
      if (last) begin
        idx_d   = '0;
        phase_d = phase_nx;
        done_d  = (phase_q == PH_DEC_U4);
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      len_q   <= LW'(1);
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      done_q  <= done_d;
    end
  end

  assign phase   = phase_q;
  assign idx     = idx_q;
  assign len_cur = len_q;
  assign done    = done_q;

endmodule

// File: rtl/sc4_gnode.sv
module sc4_gnode (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic a,
  input  logic b,
  input  logic psum,
  output logic y
);

  logic hold_q, hold_d;
  logic a_eff;
  logic hold_eff;

  // inverted first input under partial sum 1; agree -> pass, else repeat
  always_comb begin
    a_eff    = a ^ psum;
    hold_eff = clr ? 1'b0 : hold_q;
    y        = (a_eff == b) ? b : hold_eff;
    hold_d   = en ? y : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

endmodule

// File: rtl/sc4_hard_decide.sv
module sc4_hard_decide #(
  parameter int LW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          bit_in,
  input  logic [LW-1:0] len,
  output logic          one_wins
);

  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] base;
  logic [LW-1:0] total;

  // running count including the current bit; strict majority wins
  always_comb begin
    base     = clr ? '0 : cnt_q;
    total    = base + LW'(bit_in);
    one_wins = {total, 1'b0} > {1'b0, len};
    cnt_d    = en ? total : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sc4_polar_decoder.sv
module sc4_polar_decoder
  import sc4_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  localparam int LSEL_W  = $clog2(MAX_LOG2 + 1),
  localparam int LW      = MAX_LOG2 + 1,
  localparam int MAX_LEN = 1 << MAX_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LSEL_W-1:0]   len_sel,
  input  logic [CW_BITS-1:0]  frozen_mask,
  input  logic [CW_BITS-1:0]  ch_bits,
  output logic [CW_BITS-1:0]  u_bits,
  output logic                done
);

  phase_e              phase;
  logic [MAX_LOG2-1:0] idx;
  logic [LW-1:0]       len_cur;
  logic                first, last, accept;

  sc4_sequencer #(.MAX_LOG2(MAX_LOG2), .LSEL_W(LSEL_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .len_sel (len_sel),
    .phase   (phase),
    .idx     (idx),
    .len_cur (len_cur),
    .first   (first),
    .last    (last),
    .accept  (accept),
    .done    (done)
  );

  logic [CW_BITS-1:0] u_q, u_d;
  logic [CW_BITS-1:0] frozen_q, frozen_d;

  // first stage: pair j combines lanes j and j+2
  logic [1:0] s1_f;
  logic [1:0] s1_g;
  logic       s1_g_en;

  assign s1_g_en = (phase == PH_STAGE1_G);

  for (genvar j = 0; j < 2; j++) begin : g_pair
    logic ps;
    assign ps      = (j == 0) ? (u_q[0] ^ u_q[1]) : u_q[1];
    assign s1_f[j] = ch_bits[j] ^ ch_bits[j+2];

    sc4_gnode u_g1 (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (s1_g_en),
      .clr   (first),
      .a     (ch_bits[j]),
      .b     (ch_bits[j+2]),
      .psum  (ps),
      .y     (s1_g[j])
    );
  end

  // two-lane stream buffer between the stages
  logic [1:0] mem_q [MAX_LEN];
  logic       wr_en;
  logic [1:0] wr_data;
  logic [1:0] rd_data;

  always_comb begin
    wr_en   = (phase == PH_STAGE1_F) || (phase == PH_STAGE1_G);
    wr_data = (phase == PH_STAGE1_F) ? s1_f : s1_g;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx] <= wr_data;
  end

  assign rd_data = mem_q[idx];

  // last stage
  logic f_last, g_last, g_last_en, g_last_ps;
  logic dec_f, dec_g, dec_any, node_bit, one_wins;
  logic [1:0] slot;

  always_comb begin
    dec_f     = (phase == PH_DEC_U1) || (phase == PH_DEC_U3);
    dec_g     = (phase == PH_DEC_U2) || (phase == PH_DEC_U4);
    dec_any   = dec_f || dec_g;
    f_last    = rd_data[0] ^ rd_data[1];
    g_last_en = dec_g;
    g_last_ps = (phase == PH_DEC_U2) ? u_q[0] : u_q[2];
    node_bit  = dec_f ? f_last : g_last;
    case (phase)
      PH_DEC_U1: slot = 2'd0;
      PH_DEC_U2: slot = 2'd1;
      PH_DEC_U3: slot = 2'd2;
      default:   slot = 2'd3;
    endcase
  end

  sc4_gnode u_g2 (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (g_last_en),
    .clr   (first),
    .a     (rd_data[0]),
    .b     (rd_data[1]),
    .psum  (g_last_ps),
    .y     (g_last)
  );

  sc4_hard_decide #(.LW(LW)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dec_any),
    .clr      (first),
    .bit_in   (node_bit),
    .len      (len_cur),
    .one_wins (one_wins)
  );

  // decision and mask registers
  always_comb begin
    u_d      = u_q;
    frozen_d = frozen_q;
    if (accept) begin
      u_d      = '0;
      frozen_d = frozen_mask;
    end else if (dec_any && last) begin
      u_d[slot] = frozen_q[slot] ? 1'b0 : one_wins;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u_q      <= '0;
      frozen_q <= '0;
    end else begin
      u_q      <= u_d;
      frozen_q <= frozen_d;
    end
  end

  assign u_bits = u_q;

endmodule

// File: rtl/sc4_polar_checker.sv
module sc4_polar_checker
  import sc4_pkg::*;
#(
  parameter int MAX_LOG2 = 10,
  localparam int LW      = MAX_LOG2 + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                done,
  input logic [3:0]          u_bits,
  input phase_e              phase,
  input logic [MAX_LOG2-1:0] idx,
  input logic [LW-1:0]       len_q,
  input logic [3:0]          frozen_q
);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_u4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(phase) == PH_DEC_U4) && (phase == PH_IDLE));

  // R9
  frozen_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((u_bits & frozen_q) == 4'b0000));

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> ({1'b0, idx} < len_q));

  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start) |=> $stable(len_q) && $stable(frozen_q));

  // R10
  u_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> $stable(u_bits));

endmodule

bind sc4_polar_decoder sc4_polar_checker #(.MAX_LOG2(MAX_LOG2)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .done     (done),
  .u_bits   (u_bits),
  .phase    (phase),
  .idx      (idx),
  .len_q    (len_cur),
  .frozen_q (frozen_q)
);

// File: tb/sc4_polar_decoder_test.sv
module sc4_polar_decoder_test;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] len_sel;
  logic [3:0] frozen_mask;
  logic [3:0] ch_bits;
  logic [3:0] u_bits;
  logic       done;

  int checks;
  int failures;
  bit finished;

  logic [3:0] y1a [1024];
  logic [3:0] y4a [1024];

  sc4_polar_decoder uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .len_sel     (len_sel),
    .frozen_mask (frozen_mask),
    .ch_bits     (ch_bits),
    .u_bits      (u_bits),
    .done        (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic decide(input int ones, input int len);
    return (2 * ones) > len;  // R4: strict majority, tie gives 0
  endfunction

  function automatic logic [3:0] gen_ch(input int p0, input int p1, input int p2, input int p3);
    logic [3:0] b;
    b[0] = $urandom_range(255) < p0;
    b[1] = $urandom_range(255) < p1;
    b[2] = $urandom_range(255) < p2;
    b[3] = $urandom_range(255) < p3;
    return b;
  endfunction

  // reference model of the six steps, from the recorded step-1 and step-4 samples
  function automatic logic [3:0] model(input int len, input logic [3:0] frz);
    logic [3:0] u;
    logic [1:0] st [1024];
    int ones;
    logic hold, o, a, b;
    logic hg0, hg1;
    u = '0;
    for (int i = 0; i < len; i++) begin
      st[i][0] = y1a[i][0] ^ y1a[i][2];
      st[i][1] = y1a[i][1] ^ y1a[i][3];
    end
    ones = 0;
    for (int i = 0; i < len; i++) ones += int'(st[i][0] ^ st[i][1]);
    u[0] = frz[0] ? 1'b0 : decide(ones, len);
    ones = 0; hold = 1'b0;
    for (int i = 0; i < len; i++) begin
      a = st[i][0] ^ u[0]; b = st[i][1];
      o = (a == b) ? b : hold; hold = o; ones += int'(o);
    end
    u[1] = frz[1] ? 1'b0 : decide(ones, len);
    hg0 = 1'b0; hg1 = 1'b0;
    for (int i = 0; i < len; i++) begin
      a = y4a[i][0] ^ u[0] ^ u[1]; b = y4a[i][2];
      o = (a == b) ? b : hg0; hg0 = o; st[i][0] = o;
      a = y4a[i][1] ^ u[1]; b = y4a[i][3];
      o = (a == b) ? b : hg1; hg1 = o; st[i][1] = o;
    end
    ones = 0;
    for (int i = 0; i < len; i++) ones += int'(st[i][0] ^ st[i][1]);
    u[2] = frz[2] ? 1'b0 : decide(ones, len);
    ones = 0; hold = 1'b0;
    for (int i = 0; i < len; i++) begin
      a = st[i][0] ^ u[2]; b = st[i][1];
      o = (a == b) ? b : hold; hold = o; ones += int'(o);
    end
    u[3] = frz[3] ? 1'b0 : decide(ones, len);
    return u;
  endfunction

  task automatic run_decode(input int lsel, input logic [3:0] frz,
                            input int p0, input int p1, input int p2, input int p3,
                            input bit use_pat, input logic [3:0] pa, input logic [3:0] pb,
                            input bit poke, input string note);
    int len;
    logic [3:0] chosen;
    logic [3:0] exp_u;
    string tg;
    len = (lsel > 10) ? 1024 : (1 << lsel);
    @(negedge clk);
    start = 1'b1; len_sel = 4'(lsel); frozen_mask = frz; ch_bits = 4'($urandom);
    @(posedge clk);
    for (int st = 1; st <= 6; st++) begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        start = 1'b0;
        frozen_mask = 4'($urandom);   // R9: only the value at start counts
        len_sel = 4'($urandom);       // R2: only the value at start counts
        if (poke && (st == 3 || st == 5) && i == 0) start = 1'b1;  // R11
        if (st == 1 || st == 4)
          chosen = use_pat ? (((i % 2) == 0) ? pa : pb) : gen_ch(p0, p1, p2, p3);
        else
          chosen = 4'($urandom);      // R8: ignored steps see garbage
        ch_bits = chosen;
        if (st == 1) y1a[i] = chosen;
        if (st == 4) y4a[i] = chosen;
        if (st == 6 && i == len - 1)
          check_val($sformatf("R2 done early (%s)", note), int'(done), 0);
        @(posedge clk);
      end
    end
    @(negedge clk);
    start = 1'b0;
    exp_u = model(len, frz);
    tg = poke ? "R11 R2" : "R2";
    check_val($sformatf("%s done on time (%s)", tg, note), int'(done), 1);
    check_val($sformatf("R3 R8 R9 u1 (%s)", note), int'(u_bits[0]), int'(exp_u[0]));
    check_val($sformatf("R5 R6 R9 u2 (%s)", note), int'(u_bits[1]), int'(exp_u[1]));
    check_val($sformatf("R7 R9 u3 (%s)", note), int'(u_bits[2]), int'(exp_u[2]));
    check_val($sformatf("R5 R7 R9 u4 (%s)", note), int'(u_bits[3]), int'(exp_u[3]));
    @(posedge clk);
    @(negedge clk);
    check_val($sformatf("R10 done single cycle (%s)", note), int'(done), 0);
    check_val($sformatf("R10 u held (%s)", note), int'(u_bits), int'(exp_u));
  endtask

  initial begin
    finished = 1'b0;
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    checks = 0; failures = 0;
    rst_n = 1'b0; start = 1'b0; len_sel = '0; frozen_mask = '0; ch_bits = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_val("R1 done in reset", int'(done), 0);
    check_val("R1 u_bits in reset", int'(u_bits), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_val("R1 done after reset", int'(done), 0);
    check_val("R1 u_bits after reset", int'(u_bits), 0);

    run_decode(0, 4'b0000, 128, 128, 128, 128, 0, '0, '0, 0, "L=1");
    // R4: step-1 first-stage stream is 1,0 over L=2, a tie, so u1 must be 0
    run_decode(1, 4'b0000, 0, 0, 0, 0, 1, 4'b0001, 4'b0000, 0, "R4 tie");
    run_decode(3, 4'b1111, 240, 20, 230, 10, 0, '0, '0, 0, "all frozen");
    run_decode(4, 4'b0000, 256, 256, 256, 256, 0, '0, '0, 0, "all ones");
    run_decode(4, 4'b0000, 0, 0, 0, 0, 0, '0, '0, 0, "all zeros");
    run_decode(15, 4'b0001, 200, 60, 220, 40, 0, '0, '0, 0, "R2 clamp 1024");
    run_decode(5, 4'b0000, 30, 220, 60, 200, 0, '0, '0, 1, "R11 poke");
    for (int n = 0; n < 25; n++) begin
      logic [3:0] fz;
      fz = ($urandom_range(3) == 0) ? 4'($urandom) : 4'b0000;
      run_decode($urandom_range(6), fz,
                 $urandom_range(256), $urandom_range(256),
                 $urandom_range(256), $urandom_range(256),
                 0, '0, '0, bit'($urandom_range(1)), $sformatf("rand %0d", n));
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule